// File: doc/BRIEF.md
# PLL Divider Parameter Solver

This block turns a requested pixel-clock period into the settings a frequency synthesizer needs. A caller presents the reference-clock period, the reference divider, the wanted output period and an optional ceiling for the overlay clock, then pulses `start`. The block works out a scaled ratio between the two periods and checks it against a legal window. It then derives a two-bit post-divider code, the matching divide value and an eight-bit feedback divider. It also builds a clock-control byte that carries a small overlay-clock divider code.

All three divisions run in turn on one restoring divider that yields one quotient bit per clock. The first division finds the ratio. The second finds the synthesizer frequency in the units set by `FREQ_K`. The third divides that frequency by the post-divide value to give the output frequency, which is compared with the overlay ceiling. A one-cycle `done` pulse marks new results. When the ratio is out of range, `range_err` pulses together with `done` and the result outputs keep their previous values.

Top module: `pll_div_solver`

## Requirements
- R1: The ratio is q = floor(ref_period * ref_div * 4 / req_period). If q < 128 or q > 2040 (a zero `req_period` counts as out of range), then `range_err` and `done` pulse together after DW+1 clock edges counted from the edge that accepts `start`, and `post_code`, `post_real`, `fb_div` and `clk_ctrl` keep their previous values.
- R2: `post_code` is the number of true conditions among q < 1024, q < 512 and q < 256, giving a value from 0 to 3.
- R3: `post_real` is the divide value for the code: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8. A table index of 4 would give 3, but the ratio path never selects it.
- R4: `fb_div` is the low 8 bits of floor(q * post_real / 8). For any q in range this lies between 128 and 255.
- R5: `clk_ctrl` has bits [1:0] = 2'b11, bits [5:4] = the overlay divider code, and all other bits zero. With `ecp_limit` = 0 the byte is 8'h03.
- R6: When `ecp_limit` is non-zero, the output frequency is f = floor(floor(FREQ_K * 2 * fb_div / (ref_period * ref_div)) / post_real). While f > `ecp_limit` and the code is below 2, f is halved and the code goes up by one. The code never exceeds 2.
- R7: `done` is a single-cycle pulse. A successful result appears 3*(DW+1) clock edges after the edge that accepts `start`, and `done` is low in every other cycle.
- R8: A `start` pulse that arrives while a computation is in flight has no effect. The latency and the results are those of the first request, and the inputs are taken only at the edge that accepts `start`.
- R9: After reset, `done`, `range_err`, `post_code`, `post_real`, `fb_div` and `clk_ctrl` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a computation; taken only when idle |
| ref_period | input | PER_W | Reference-clock period |
| ref_div | input | RDIV_W | Reference divider |
| req_period | input | PER_W | Requested output-clock period |
| ecp_limit | input | LIM_W | Overlay clock ceiling; zero disables the halving |
| done | output | 1 | One-cycle pulse when results (or an error) are ready |
| range_err | output | 1 | Pulses with `done` when the ratio is out of range |
| post_code | output | 2 | Post-divider code |
| post_real | output | 4 | Real post-divide value |
| fb_div | output | 8 | Feedback divider |
| clk_ctrl | output | 8 | Clock-control byte with the overlay divider code in [5:4] |

## Verification
The bench builds the block with its default parameters: 17-bit periods, an 8-bit reference divider, a 16-bit overlay ceiling and a frequency scale of one million. These values let realistic picosecond periods drive the ratio onto every threshold (128, 256, 512, 1024 and 2040, and one past each window edge). They also produce output frequencies large enough for the overlay ceiling to reach code 0, code 1 and the cap at code 2. Each request is compared cycle by cycle against a behavioural model that predicts when `done` will rise and which values it will carry.

// File: rtl/pll_solver_pkg.sv
package pll_solver_pkg;

  localparam int SOLVE_W = 32;
  localparam int Q_LO    = 128;
  localparam int Q_HI    = 2040;

  typedef enum logic [1:0] {
    PH_RATIO = 2'd0,
    PH_VCO   = 2'd1,
    PH_OUT   = 2'd2
  } phase_e;

  // Number of ratio thresholds that q lies below (R2)
  function automatic logic [1:0] post_code_of(input logic [SOLVE_W-1:0] q);
    logic [1:0] c;
    c = 2'd0;
    if (q < SOLVE_W'(1024)) c = c + 2'd1;
    if (q < SOLVE_W'(512))  c = c + 2'd1;
    if (q < SOLVE_W'(256))  c = c + 2'd1;
    return c;
  endfunction

  // Divide value selected by a table index (R3)
  function automatic logic [3:0] post_real_of(input logic [2:0] idx);
    case (idx)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd8;
      default: return 4'd3;
    endcase
  endfunction

  // Feedback divider: q times a power-of-two divide value, over eight (R4)
  function automatic logic [7:0] fb_of(input logic [SOLVE_W-1:0] q);
    return 8'((q << post_code_of(q)) >> 3);
  endfunction

  function automatic logic [7:0] ctrl_of(input logic [1:0] ecp_code);
    return {2'b00, ecp_code, 4'b0011};
  endfunction

endpackage

// File: rtl/pll_solver_div.sv
module pll_solver_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         finish
);
  localparam int CW = $clog2(W) + 1;

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  dsr_q;
  logic [CW-1:0] cnt_q;
  logic          active_q;

  logic [W:0]    rem_shift;
  logic          take_bit;
  logic [W:0]    rem_next;

  // One restoring step: shift in the next dividend bit, subtract if it fits
  always_comb begin
    rem_shift = {rem_q[W-1:0], quo_q[W-1]};
    take_bit  = (rem_shift >= {1'b0, dsr_q});
    rem_next  = take_bit ? (rem_shift - {1'b0, dsr_q}) : rem_shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      quo_q    <= '0;
      dsr_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      finish   <= 1'b0;
    end else if (load) begin
      rem_q    <= '0;
      quo_q    <= dividend;
      dsr_q    <= divisor;
      cnt_q    <= '0;
      active_q <= 1'b1;
      finish   <= 1'b0;
    end else if (active_q) begin
      rem_q  <= rem_next;
      quo_q  <= {quo_q[W-2:0], take_bit};
      cnt_q  <= cnt_q + CW'(1);
      finish <= (cnt_q == CW'(W - 1));
      if (cnt_q == CW'(W - 1)) active_q <= 1'b0;
    end else begin
      finish <= 1'b0;
    end
  end

  assign quotient = quo_q;

  // R7: each division signals its end for exactly one cycle
  a_r7_finish_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !finish);

  // R7: the step counter never passes the last quotient bit
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < CW'(W)));

endmodule

// File: rtl/pll_solver_ecp.sv
module pll_solver_ecp #(
  parameter int W         = 32,
  parameter int LIM_W     = 16,
  parameter int ECP_STEPS = 2
) (
  input  logic [W-1:0]     freq,
  input  logic [LIM_W-1:0] limit,
  output logic [1:0]       code
);
  logic [W-1:0] f;

  // Halve the output frequency while it is above the ceiling, at most ECP_STEPS times
  always_comb begin
    f    = freq;
    code = 2'd0;
    if (limit != '0) begin
      for (int i = 0; i < ECP_STEPS; i++) begin
        if (f > W'(limit)) begin
          f    = f >> 1;
          code = code + 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/pll_div_solver.sv
module pll_div_solver
  import pll_solver_pkg::*;
#(
  parameter int          PER_W  = 17,
  parameter int          RDIV_W = 8,
  parameter int          LIM_W  = 16,
  parameter int unsigned FREQ_K = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PER_W-1:0]  ref_period,
  input  logic [RDIV_W-1:0] ref_div,
  input  logic [PER_W-1:0]  req_period,
  input  logic [LIM_W-1:0]  ecp_limit,
  output logic              done,
  output logic              range_err,
  output logic [1:0]        post_code,
  output logic [3:0]        post_real,
  output logic [7:0]        fb_div,
  output logic [7:0]        clk_ctrl
);
  localparam int DW = SOLVE_W;

  logic              busy;
  phase_e            phase;
  logic [PER_W-1:0]  rp_l;
  logic [RDIV_W-1:0] rd_l;
  logic [LIM_W-1:0]  lim_l;
  logic [1:0]        code_r;
  logic [7:0]        fb_r;

  logic          accept;
  logic          div_load;
  logic [DW-1:0] div_num;
  logic [DW-1:0] div_den;
  logic [DW-1:0] div_quo;
  logic          div_end;
  logic          q_bad;
  logic          step_end;
  logic [1:0]    ecp_code;

  assign accept   = start && !busy;
  assign step_end = busy && div_end;
  assign q_bad    = (div_quo < DW'(Q_LO)) || (div_quo > DW'(Q_HI));

  // Operand selection for the shared divider
  always_comb begin
    div_load = 1'b0;
    div_num  = '0;
    div_den  = '0;
    if (accept) begin
      div_load = 1'b1;
      div_num  = (DW'(ref_period) * DW'(ref_div)) << 2;
      div_den  = DW'(req_period);
    end else if (step_end) begin
      case (phase)
        PH_RATIO: if (!q_bad) begin
          div_load = 1'b1;
          div_num  = (DW'(FREQ_K) * DW'(fb_of(div_quo))) << 1;
          div_den  = DW'(rp_l) * DW'(rd_l);
        end
        PH_VCO: begin
          div_load = 1'b1;
          div_num  = div_quo;
          div_den  = DW'(post_real_of({1'b0, code_r}));
        end
        default: ;
      endcase
    end
  end

  pll_solver_div #(.W(DW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (div_load),
    .dividend (div_num),
    .divisor  (div_den),
    .quotient (div_quo),
    .finish   (div_end)
  );

  pll_solver_ecp #(.W(DW), .LIM_W(LIM_W), .ECP_STEPS(2)) u_ecp (
    .freq  (div_quo),
    .limit (lim_l),
    .code  (ecp_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      phase     <= PH_RATIO;
      rp_l      <= '0;
      rd_l      <= '0;
      lim_l     <= '0;
      code_r    <= '0;
      fb_r      <= '0;
      done      <= 1'b0;
      range_err <= 1'b0;
      post_code <= '0;
      post_real <= '0;
      fb_div    <= '0;
      clk_ctrl  <= '0;
    end else begin
      done      <= 1'b0;
      range_err <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        phase <= PH_RATIO;
        rp_l  <= ref_period;
        rd_l  <= ref_div;
        lim_l <= ecp_limit;
      end else if (step_end) begin
        case (phase)
          PH_RATIO: begin
            if (q_bad) begin
              busy      <= 1'b0;
              done      <= 1'b1;
              range_err <= 1'b1;
            end else begin
              code_r <= post_code_of(div_quo);
              fb_r   <= fb_of(div_quo);
              phase  <= PH_VCO;
            end
          end
          PH_VCO: phase <= PH_OUT;
          default: begin
            busy      <= 1'b0;
            done      <= 1'b1;
            post_code <= code_r;
            post_real <= post_real_of({1'b0, code_r});
            fb_div    <= fb_r;
            clk_ctrl  <= ctrl_of(ecp_code);
          end
        endcase
      end
    end
  end

  // R1: the error flag appears only together with done
  a_r1_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> done);

  // R1: an error leaves every result output untouched
  a_r1_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> ($stable(fb_div) && $stable(post_code) && $stable(post_real) && $stable(clk_ctrl)));

  // R3: the reported divide value matches the reported code
  a_r3_real_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !range_err) |-> (post_real == (4'd1 << post_code)));

  // R4: an in-range ratio always gives a feedback divider in 128..255
  a_r4_fb_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !range_err) |-> fb_div[7]);

  // R5: fixed bits of the control byte
  a_r5_ctrl_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !range_err) |-> (clk_ctrl[1:0] == 2'b11 && clk_ctrl[3:2] == 2'b00 && clk_ctrl[7:6] == 2'b00));

  // R6: the overlay divider code stops at 2
  a_r6_ecp_cap: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (clk_ctrl[5:4] != 2'b11));

  // R7: done lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a start while busy does not re-latch the inputs
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(rp_l) && $stable(rd_l) && $stable(lim_l)));

endmodule

// File: tb/tb_pll_div_solver.sv
`timescale 1ns/1ps
module tb_pll_div_solver;

  localparam int LAT_ERR = 33;   // DW+1 with DW = 32
  localparam int LAT_OK  = 99;   // 3*(DW+1)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [16:0] ref_period = '0;
  logic [7:0]  ref_div = '0;
  logic [16:0] req_period = '0;
  logic [15:0] ecp_limit = '0;
  logic        done, range_err;
  logic [1:0]  post_code;
  logic [3:0]  post_real;
  logic [7:0]  fb_div, clk_ctrl;

  int n_chk = 0;
  int n_err = 0;
  longint e_code = 0, e_real = 0, e_fb = 0, e_ctrl = 0;

  always #10 clk = ~clk;

  pll_div_solver dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ref_period(ref_period), .ref_div(ref_div), .req_period(req_period),
    .ecp_limit(ecp_limit), .done(done), .range_err(range_err),
    .post_code(post_code), .post_real(post_real), .fb_div(fb_div), .clk_ctrl(clk_ctrl)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input longint rp, input longint rd, input longint req, input longint lim,
                       output bit err, output longint code, output longint rv,
                       output longint fb, output longint ctrl);
    longint q, pll, f, e;
    err = 0; code = 0; rv = 1; fb = 0; ctrl = 3;
    if (req == 0) begin err = 1; return; end
    q = (rp * rd * 4) / req;
    if (q < 128 || q > 2040) begin err = 1; return; end
    if (q < 1024) code++;
    if (q < 512) code++;
    if (q < 256) code++;
    rv = 1 << code;
    fb = ((q * rv) / 8) % 256;
    pll = (64'd1000000 * 2 * fb) / (rp * rd);
    f = pll / rv;
    e = 0;
    if (lim != 0)
      while (f > lim && e < 2) begin f = f / 2; e++; end
    ctrl = 3 + e * 16;
  endtask

  task automatic run(input longint rp, input longint rd, input longint req, input longint lim,
                     input bit poke, input string tag);
    bit err;
    longint code, rv, fb, ctrl;
    int lat;
    model(rp, rd, req, lim, err, code, rv, fb, ctrl);
    lat = err ? LAT_ERR : LAT_OK;
    if (!err) begin e_code = code; e_real = rv; e_fb = fb; e_ctrl = ctrl; end
    @(negedge clk);
    ref_period = 17'(rp); ref_div = 8'(rd); req_period = 17'(req); ecp_limit = 16'(lim);
    start = 1'b1;
    for (int k = 0; k <= lat + 1; k++) begin
      @(negedge clk);
      // R7: done only in the predicted cycle; R8: poke must not disturb it
      chk(done == (k == lat), poke ? "R8 done timing" : "R7 done timing", done, (k == lat));
      if (k == lat) begin
        chk(range_err == err, {"R1 range_err ", tag}, range_err, err);
        chk(post_code == e_code, {"R2 post_code ", tag}, post_code, e_code);
        chk(post_real == e_real, {"R3 post_real ", tag}, post_real, e_real);
        chk(fb_div == e_fb, {"R4 fb_div ", tag}, fb_div, e_fb);
        chk(clk_ctrl == e_ctrl, {(lim != 0) ? "R6 clk_ctrl " : "R5 clk_ctrl ", tag}, clk_ctrl, e_ctrl);
      end
      start = 1'b0;
      if (poke && k == 4) begin
        start = 1'b1; ref_period = 17'd1000; ref_div = 8'd1; req_period = 17'd1; ecp_limit = 16'd1;
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(done == 0, "R9 done", done, 0);
    chk(range_err == 0, "R9 range_err", range_err, 0);
    chk(post_code == 0 && post_real == 0, "R9 post", {post_code, post_real}, 0);
    chk(fb_div == 0 && clk_ctrl == 0, "R9 fb/ctrl", {fb_div, clk_ctrl}, 0);

    run(69841, 23, 39722, 0,  0, "nominal");
    run(69841, 23, 39722, 20, 0, "ecp one halving");
    run(69841, 23, 39722, 5,  0, "ecp capped");
    run(65535, 8, 1028,  0,   0, "q=2040 upper edge");
    run(65535, 8, 1027,  0,   0, "q=2041 R1 above window");
    run(65535, 8, 16383, 0,   0, "q=128 lower edge");
    run(65535, 8, 16384, 0,   0, "q=127 R1 below window");
    run(65535, 8, 2047,  100, 0, "q=1024");
    run(65535, 8, 2048,  500, 0, "q=1023");
    run(65535, 8, 4095,  0,   0, "q=512");
    run(65535, 8, 8191,  0,   0, "q=256");
    run(65535, 8, 0,     0,   0, "zero period R1");
    run(69841, 23, 39722, 20, 1, "busy start R8");
    run(14318, 2, 2000,  40,  0, "second reference");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule